// File: doc/BRIEF.md
# Program Run Outcome Classifier

This block watches one program run on a processor core and gives it one final verdict: crash, hang, silent data corruption, or no effect. The core sends single-cycle strobes when something goes wrong. These cover a memory access with its address and size code, a divide with its divisor, an integer overflow, an illegal opcode and a failed system call. The core also sends one tick per executed cycle and a strobe when the run finishes. A fault-free reference run supplies its cycle count, its number of output words and the golden value of each output word. The block does not produce these reference values.

The output words arrive on a valid/ready stream together with their golden counterparts. `out_ready` is high while the run is being monitored and drops for good once a verdict exists. After that the source has to stop offering words, because they are never accepted. A beat transfers on any cycle where both `out_valid` and `out_ready` are high. The first crash or hang ends monitoring at once. Without either, the verdict is settled when the run-end strobe arrives. The verdict stays on the outputs until reset.

Top module: `run_verdict`

## Requirements
- R1: After reset `verdict_valid` is 0, `verdict_code` is 0 and `crash_cause` is 0. Once `verdict_valid` rises, it and both verdict fields hold their values until the next reset. `crash_cause` is nonzero exactly when the code is crash.
- R2: The verdict code is 2'b00 for no effect, 2'b01 for crash, 2'b10 for hang and 2'b11 for SDC. The verdict appears on the cycle after the edge that samples its cause.
- R3: A memory access with size code s (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes) whose address has any of its low s bits set is a crash with cause 3'd1 (misaligned). This holds even when the address is also out of range.
- R4: An aligned access whose address is below `cfg_addr_lo` or above `cfg_addr_hi` is a crash with cause 3'd2. An aligned access inside the range is not a crash.
- R5: A divide strobe with a zero divisor is a crash with cause 3'd3. A divide with a nonzero divisor is not a crash.
- R6: An overflow strobe gives cause 3'd4, an illegal opcode gives 3'd5 and a system-call error gives 3'd6. When several causes arrive on one cycle, the lowest code wins.
- R7: A hang is declared on the tick that brings the elapsed tick count above five times `cfg_golden_cycles`. The tick that makes the count equal to that limit does not declare a hang.
- R8: If a crash cause and the hang-producing tick arrive on the same cycle, the verdict is crash.
- R9: At run end, if any accepted output word has differed from its golden word, the verdict is SDC.
- R10: At run end, if the number of accepted words differs from `cfg_golden_words`, whether fewer or more, the verdict is SDC.
- R11: At run end, if the word count matches and every word matched its golden word, the verdict is no effect.
- R12: Once a verdict exists, `out_ready` is 0. Later strobes, ticks, words and run-end pulses do not change the verdict.
- R13: While no verdict exists, `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_golden_cycles | input | CYC_W | Cycle count of the reference run |
| cfg_golden_words | input | CNT_W | Number of output words in the reference run |
| cfg_addr_lo | input | ADDR_W | Lowest valid address (inclusive) |
| cfg_addr_hi | input | ADDR_W | Highest valid address (inclusive) |
| mem_valid | input | 1 | Memory access strobe |
| mem_addr | input | ADDR_W | Access address |
| mem_size | input | 2 | Access size code (bytes = 2^code) |
| div_valid | input | 1 | Divide strobe |
| div_divisor | input | DATA_W | Divisor operand |
| ovf_flag | input | 1 | Integer overflow strobe |
| illegal_op | input | 1 | Invalid instruction strobe |
| syscall_err | input | 1 | System call failure strobe |
| tick | input | 1 | One pulse per executed cycle |
| run_end | input | 1 | Program finished strobe |
| out_valid | input | 1 | Output word offered |
| out_ready | output | 1 | Output word accepted while monitoring |
| out_word | input | DATA_W | Output word from the run |
| gold_word | input | DATA_W | Matching reference word |
| verdict_valid | output | 1 | Verdict present (held) |
| verdict_code | output | 2 | Outcome code |
| crash_cause | output | 3 | Crash sub-cause, 0 when not a crash |

## Verification
The hardest cases to reach are the exact hang boundary and a crash that lands on the same cycle as the timeout tick. The stimulus keeps the tick line high for exactly the limit of five times the golden count. It checks that no verdict has appeared, and then gives one more tick. In a separate run, that final tick carries a system-call error alongside it. Extra and missing output words are produced by streaming one word more or one word fewer than the golden count before run end. A verdict that already exists is then hit with further events and words, and must not change.

// File: rtl/rv_pkg.sv
package rv_pkg;
  typedef enum logic [1:0] {
    VERD_CLEAN = 2'b00,
    VERD_CRASH = 2'b01,
    VERD_HANG  = 2'b10,
    VERD_SDC   = 2'b11
  } verdict_e;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_ALIGN   = 3'd1,
    CZ_RANGE   = 3'd2,
    CZ_DIVZERO = 3'd3,
    CZ_OVF     = 3'd4,
    CZ_ILLEGAL = 3'd5,
    CZ_SYSCALL = 3'd6
  } cause_e;

  localparam int unsigned HANG_MULT = 5;
endpackage

// File: rtl/rv_fault_scan.sv
module rv_fault_scan
  import rv_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [1:0]        mem_size,
  input  logic              div_valid,
  input  logic [DATA_W-1:0] div_divisor,
  input  logic              ovf_flag,
  input  logic              illegal_op,
  input  logic              syscall_err,
  output logic              hit,
  output cause_e            cause
);
  localparam int unsigned NSRC = 6;

  logic [ADDR_W-1:0] low_mask;
  logic              misal;
  logic              outside;
  logic [NSRC-1:0]   flags;

  always_comb begin
    low_mask = ADDR_W'((1 << mem_size) - 1);
    misal    = mem_valid && ((mem_addr & low_mask) != '0);
    outside  = mem_valid && ((mem_addr < addr_lo) || (mem_addr > addr_hi));
  end

  assign flags = {syscall_err, illegal_op, ovf_flag,
                  div_valid && (div_divisor == '0), outside, misal};

  // lowest index wins: loop from highest down so the last assignment sticks
  always_comb begin
    hit   = |flags;
    cause = CZ_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (flags[i]) cause = cause_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/rv_watchdog.sv
module rv_watchdog
  import rv_pkg::*;
#(
  parameter int unsigned CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CYC_W-1:0] golden,
  output logic             expire
);
  localparam int unsigned LIM_W = CYC_W + 3;

  logic [LIM_W-1:0] elapsed_q;
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] elapsed_nx;

  assign limit      = LIM_W'(golden) * LIM_W'(HANG_MULT);
  assign elapsed_nx = (elapsed_q == '1) ? elapsed_q : elapsed_q + 1'b1;
  assign expire     = en && tick && (elapsed_nx > limit);

  always_ff @(posedge clk) begin
    if (!rst_n) elapsed_q <= '0;
    else if (en && tick) elapsed_q <= elapsed_nx;
  end
endmodule

// File: rtl/rv_stream_cmp.sv
module rv_stream_cmp #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] gold,
  input  logic [CNT_W-1:0]  golden_words,
  output logic              sdc_now
);
  localparam int unsigned N_W = CNT_W + 1;

  logic           bad_q;
  logic [N_W-1:0] seen_q;
  logic           beat;
  logic           beat_bad;
  logic [N_W-1:0] seen_nx;

  assign in_ready = en;
  assign beat     = in_valid && in_ready;
  assign beat_bad = beat && ((word != gold) || (seen_q >= N_W'(golden_words)));
  assign seen_nx  = (beat && seen_q != '1) ? seen_q + 1'b1 : seen_q;
  assign sdc_now  = bad_q || beat_bad || (seen_nx != N_W'(golden_words));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_q  <= 1'b0;
      seen_q <= '0;
    end else begin
      if (beat_bad) bad_q <= 1'b1;
      seen_q <= seen_nx;
    end
  end
endmodule

// File: rtl/run_verdict.sv
module run_verdict
  import rv_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CYC_W  = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cfg_golden_cycles,
  input  logic [CNT_W-1:0]  cfg_golden_words,
  input  logic [ADDR_W-1:0] cfg_addr_lo,
  input  logic [ADDR_W-1:0] cfg_addr_hi,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [1:0]        mem_size,
  input  logic              div_valid,
  input  logic [DATA_W-1:0] div_divisor,
  input  logic              ovf_flag,
  input  logic              illegal_op,
  input  logic              syscall_err,
  input  logic              tick,
  input  logic              run_end,
  input  logic              out_valid,
  output logic              out_ready,
  input  logic [DATA_W-1:0] out_word,
  input  logic [DATA_W-1:0] gold_word,
  output logic              verdict_valid,
  output logic [1:0]        verdict_code,
  output logic [2:0]        crash_cause
);
  logic   watching_q;
  logic   crash_hit;
  cause_e crash_id;
  logic   hang_hit;
  logic   sdc_now;

  rv_fault_scan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_scan (
    .addr_lo(cfg_addr_lo), .addr_hi(cfg_addr_hi),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
    .div_valid(div_valid), .div_divisor(div_divisor),
    .ovf_flag(ovf_flag), .illegal_op(illegal_op), .syscall_err(syscall_err),
    .hit(crash_hit), .cause(crash_id)
  );

  rv_watchdog #(.CYC_W(CYC_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en(watching_q), .tick(tick),
    .golden(cfg_golden_cycles), .expire(hang_hit)
  );

  rv_stream_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(watching_q),
    .in_valid(out_valid), .in_ready(out_ready),
    .word(out_word), .gold(gold_word),
    .golden_words(cfg_golden_words), .sdc_now(sdc_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watching_q    <= 1'b1;
      verdict_valid <= 1'b0;
      verdict_code  <= VERD_CLEAN;
      crash_cause   <= CZ_NONE;
    end else if (watching_q) begin
      if (crash_hit) begin
        watching_q    <= 1'b0;
        verdict_valid <= 1'b1;
        verdict_code  <= VERD_CRASH;
        crash_cause   <= crash_id;
      end else if (hang_hit) begin
        watching_q    <= 1'b0;
        verdict_valid <= 1'b1;
        verdict_code  <= VERD_HANG;
      end else if (run_end) begin
        watching_q    <= 1'b0;
        verdict_valid <= 1'b1;
        verdict_code  <= sdc_now ? VERD_SDC : VERD_CLEAN;
      end
    end
  end
endmodule

// File: rtl/run_verdict_chk.sv
module run_verdict_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              verdict_valid,
  input logic [1:0]        verdict_code,
  input logic [2:0]        crash_cause,
  input logic              out_ready,
  input logic              mem_valid,
  input logic              div_valid,
  input logic [DATA_W-1:0] div_divisor,
  input logic              syscall_err
);
  // R1
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> verdict_valid && $stable(verdict_code) && $stable(crash_cause));

  // R1
  cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> ((verdict_code == 2'b01) == (crash_cause != 3'd0)));

  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> !out_ready);

  // R13
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> out_ready);

  // R5
  divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!verdict_valid && div_valid && div_divisor == '0 && !mem_valid)
      |=> (verdict_code == 2'b01 && crash_cause == 3'd3));

  // R6
  syscall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!verdict_valid && syscall_err) |=> (verdict_valid && verdict_code == 2'b01));
endmodule

bind run_verdict run_verdict_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .verdict_valid(verdict_valid),
  .verdict_code(verdict_code), .crash_cause(crash_cause),
  .out_ready(out_ready), .mem_valid(mem_valid), .div_valid(div_valid),
  .div_divisor(div_divisor), .syscall_err(syscall_err)
);

// File: tb/run_verdict_tb.sv
`timescale 1ns/1ps
module run_verdict_tb;
  localparam int AW = 16, DW = 16, CW = 16, NW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_golden_cycles = 16'd4;
  logic [NW-1:0] cfg_golden_words  = 12'd3;
  logic [AW-1:0] cfg_addr_lo = 16'h0100;
  logic [AW-1:0] cfg_addr_hi = 16'h01FF;
  logic mem_valid, div_valid, ovf_flag, illegal_op, syscall_err, tick, run_end, out_valid;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] div_divisor, out_word, gold_word;
  logic out_ready, verdict_valid;
  logic [1:0] verdict_code;
  logic [2:0] crash_cause;

  int n_tests = 0, n_fail = 0;
  logic [4:0] expq[$];
  bit got = 0;

  always #5 clk = ~clk;

  run_verdict #(.ADDR_W(AW), .DATA_W(DW), .CYC_W(CW), .CNT_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_golden_cycles(cfg_golden_cycles),
    .cfg_golden_words(cfg_golden_words), .cfg_addr_lo(cfg_addr_lo),
    .cfg_addr_hi(cfg_addr_hi), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_size(mem_size), .div_valid(div_valid), .div_divisor(div_divisor),
    .ovf_flag(ovf_flag), .illegal_op(illegal_op), .syscall_err(syscall_err),
    .tick(tick), .run_end(run_end), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .gold_word(gold_word), .verdict_valid(verdict_valid),
    .verdict_code(verdict_code), .crash_cause(crash_cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected verdict when one appears
  always @(negedge clk) begin
    if (rst_n && verdict_valid && !got) begin
      got = 1;
      if (expq.size() == 0) check(0, "R2 unexpected verdict", {verdict_code, crash_cause}, -1);
      else begin
        logic [4:0] e;
        e = expq.pop_front();
        check({verdict_code, crash_cause} == e, "R2 verdict", {verdict_code, crash_cause}, e);
      end
    end
  end

  task automatic idle();
    mem_valid = 0; mem_addr = '0; mem_size = '0; div_valid = 0; div_divisor = '0;
    ovf_flag = 0; illegal_op = 0; syscall_err = 0; tick = 0; run_end = 0;
    out_valid = 0; out_word = '0; gold_word = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    expq.delete();
    got = 0;
    @(negedge clk); #1;
  endtask

  task automatic step(); @(negedge clk); #1; idle(); endtask

  task automatic push_exp(input logic [1:0] c, input logic [2:0] z); expq.push_back({c, z}); endtask

  task automatic wait_verdict(input string req);
    repeat (3) @(negedge clk);
    #1;
    check(got, req, got, 1);
  endtask

  task automatic mem_acc(input logic [AW-1:0] a, input logic [1:0] s);
    mem_valid = 1; mem_addr = a; mem_size = s; step();
  endtask

  task automatic word(input logic [DW-1:0] w, input logic [DW-1:0] g);
    out_valid = 1; out_word = w; gold_word = g; step();
  endtask

  task automatic end_run(); run_end = 1; step(); endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    do_reset();
    // R1 R13 reset state
    check(verdict_valid == 0 && verdict_code == 0 && crash_cause == 0, "R1 reset", {verdict_valid, verdict_code, crash_cause}, 0);
    check(out_ready == 1, "R13 ready while monitoring", out_ready, 1);

    // R11 clean run
    push_exp(2'b00, 3'd0);
    word(16'h11, 16'h11); word(16'h22, 16'h22); word(16'h33, 16'h33); end_run();
    wait_verdict("R11 clean verdict");

    // R9 word mismatch
    do_reset(); push_exp(2'b11, 3'd0);
    word(16'h11, 16'h11); word(16'h20, 16'h22); word(16'h33, 16'h33); end_run();
    wait_verdict("R9 mismatch verdict");

    // R10 missing word
    do_reset(); push_exp(2'b11, 3'd0);
    word(16'h11, 16'h11); word(16'h22, 16'h22); end_run();
    wait_verdict("R10 missing word");

    // R10 extra word
    do_reset(); push_exp(2'b11, 3'd0);
    word(1, 1); word(2, 2); word(3, 3); word(4, 4); end_run();
    wait_verdict("R10 extra word");

    // R3 misaligned in range
    do_reset(); push_exp(2'b01, 3'd1);
    mem_acc(16'h0102, 2'd2);
    wait_verdict("R3 misaligned");

    // R3 misaligned and out of range: alignment wins
    do_reset(); push_exp(2'b01, 3'd1);
    mem_acc(16'h0201, 2'd1);
    wait_verdict("R3 misaligned over range");

    // R4 aligned in range is harmless, then out of range
    do_reset();
    mem_acc(16'h0108, 2'd3); mem_acc(16'h01FF, 2'd0);
    check(verdict_valid == 0, "R4 in-range access", verdict_valid, 0);
    push_exp(2'b01, 3'd2);
    mem_acc(16'h0300, 2'd2);
    wait_verdict("R4 out of range");

    // R5 nonzero divisor harmless, zero crashes
    do_reset();
    div_valid = 1; div_divisor = 16'd7; step();
    check(verdict_valid == 0, "R5 nonzero divide", verdict_valid, 0);
    push_exp(2'b01, 3'd3);
    div_valid = 1; div_divisor = 16'd0; step();
    wait_verdict("R5 divide by zero");

    // R6 individual causes and priority
    do_reset(); push_exp(2'b01, 3'd4); ovf_flag = 1; step(); wait_verdict("R6 overflow");
    do_reset(); push_exp(2'b01, 3'd5); illegal_op = 1; step(); wait_verdict("R6 illegal");
    do_reset(); push_exp(2'b01, 3'd6); syscall_err = 1; step(); wait_verdict("R6 syscall");
    do_reset(); push_exp(2'b01, 3'd4); ovf_flag = 1; syscall_err = 1; illegal_op = 1; step();
    wait_verdict("R6 priority");

    // R7 hang boundary: limit 20 ticks
    do_reset();
    tick = 1;
    repeat (20) @(negedge clk);
    #1; tick = 0;
    check(verdict_valid == 0, "R7 no hang at limit", verdict_valid, 0);
    push_exp(2'b10, 3'd0);
    tick = 1; step();
    wait_verdict("R7 hang");

    // R12 later events ignored
    mem_acc(16'h0001, 2'd1); syscall_err = 1; step(); word(5, 6); end_run();
    check(verdict_code == 2'b10 && crash_cause == 0, "R12 verdict held", verdict_code, 2);
    check(out_ready == 0, "R12 ready low", out_ready, 0);

    // R8 crash beats hang on same cycle
    do_reset();
    tick = 1;
    repeat (20) @(negedge clk);
    #1;
    push_exp(2'b01, 3'd6);
    syscall_err = 1; step();
    wait_verdict("R8 crash over hang");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule